// File: doc/BRIEF.md
# Complex Radix-2 Butterfly with Round-Half-to-Even

This block is one radix-2 butterfly for a pipelined FFT. Each enabled cycle it accepts two complex samples and one complex twiddle coefficient. It returns two complex results. The first is the plain sum of the two samples, one bit wider than the inputs and not shifted. The second is the difference of the two samples multiplied by the coefficient. That product is brought back to the output width by dropping CWIDTH-2 fraction bits with round-half-to-even.

All complex quantities are packed as {real, imaginary}, each half being a two's-complement field. The coefficient is a signed fixed-point number with CWIDTH-2 fraction bits, so the value 1.0 is 2^(CWIDTH-2). A sync flag travels with the data and has the same latency. The pipeline advances only on cycles where the clock enable is high, which lets the stage run at a fraction of the clock rate. Neither result saturates or scales. Results that do not fit simply wrap to OWIDTH = IWIDTH+1 bits.

Top module: `cplx_butterfly`

## Requirements
- R1: Every complex port is packed with the real part in the upper half and the imaginary part in the lower half, each half a two's-complement field. The halves are IWIDTH bits for the samples, CWIDTH bits for the coefficient and IWIDTH+1 bits for the results.
- R2: The left result is L+R, formed separately for the real and imaginary parts at IWIDTH+1 bits, with no shift.
- R3: The real part of the right result is cr*(Lr-Rr) - ci*(Li-Ri), scaled down by 2^(CWIDTH-2).
- R4: The imaginary part of the right result is cr*(Li-Ri) + ci*(Lr-Rr), scaled down by the same factor.
- R5: The scaling rounds to the nearest integer, and an exact tie goes to the even neighbour. For example, 0.5 gives 0, 1.5 gives 2, -0.5 gives 0 and -1.5 gives -2.
- R6: A rounded right result that does not fit in IWIDTH+1 bits keeps only its low IWIDTH+1 bits. It wraps and does not saturate.
- R7: Both results and o_sync appear together, exactly four enabled cycles after the inputs were taken. Disabled cycles between them do not count.
- R8: On a cycle with i_ce low, o_left, o_right and o_sync keep their values.
- R9: While i_reset is high, the next clock edge sets o_sync, o_left and o_right to zero and empties the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_clk | input | 1 | Clock |
| i_reset | input | 1 | Synchronous reset, active high |
| i_ce | input | 1 | Clock enable; the pipeline advances only when high |
| i_coef | input | 2*CWIDTH | Twiddle coefficient {real, imag} |
| i_left | input | 2*IWIDTH | Left sample {real, imag} |
| i_right | input | 2*IWIDTH | Right sample {real, imag} |
| i_sync | input | 1 | Marks the first sample pair of a frame |
| o_left | output | 2*(IWIDTH+1) | Sum result {real, imag} |
| o_right | output | 2*(IWIDTH+1) | Rounded twiddled difference {real, imag} |
| o_sync | output | 1 | Sync flag aligned with the results |

## Verification
The bench builds the block with IWIDTH=12 and CWIDTH=16, which gives 13-bit results and 14 fraction bits in the coefficient. With fields this narrow, random stimulus often reaches full-scale and most-negative operands, so the sum's extra bit and the wrap of the right result are both exercised. Exact ties can be produced with a coefficient of 0.5 and odd differences, which makes the even-rounding choice visible on both signs. Random stalls of the enable, placed between the directed cases, show that the latency is counted in enabled cycles only.

// File: rtl/cplx_bfly_pkg.sv
package cplx_bfly_pkg;

  // Number of enabled cycles from input capture to result.
  localparam int BFLY_LATENCY = 4;

  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic advance;
    logic clear;
  } bflyCtrl_t;

endpackage

// File: rtl/cplx_bfly_ctrl.sv
module cplx_bfly_ctrl
  import cplx_bfly_pkg::*;
#(
  parameter int LATENCY = BFLY_LATENCY
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      ce,
  input  logic      syncIn,
  output bflyCtrl_t ctrl,
  output logic      syncOut
);

  logic [LATENCY-1:0] syncPipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncPipe <= '0;
    end else if (ce) begin
      syncPipe <= {syncPipe[LATENCY-2:0], syncIn};
    end
  end

  assign syncOut      = syncPipe[LATENCY-1];
  assign ctrl.advance = ce;
  assign ctrl.clear   = rst;

  AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(syncOut)); // R8

  AST_SYNC_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    $rose(syncOut) |-> $past(ce)); // R7

endmodule

// File: rtl/cplx_bfly_round.sv
module cplx_bfly_round
  import cplx_bfly_pkg::*;
#(
  parameter int OWIDTH = 17,
  parameter int SHIFT  = 18,
  localparam int RW    = OWIDTH + SHIFT
) (
  input  logic              clk,
  input  bflyCtrl_t         ctrl,
  input  logic [RW-1:0]     prodIn,
  output logic [OWIDTH-1:0] roundOut
);

  // Round up when the dropped part is above one half, or exactly one half
  // while the kept part is odd (ties go to even).
  logic roundUp;
  assign roundUp = prodIn[SHIFT-1] & (prodIn[SHIFT] | (|prodIn[SHIFT-2:0]));

  always_ff @(posedge clk) begin
    if (ctrl.clear) begin
      roundOut <= '0;
    end else if (ctrl.advance) begin
      roundOut <= prodIn[RW-1:SHIFT] + OWIDTH'(roundUp);
    end
  end

  AST_ROUND_TIE_EVEN: assert property (@(posedge clk) disable iff (ctrl.clear)
    (ctrl.advance && prodIn[SHIFT-1] && (prodIn[SHIFT-2:0] == '0))
      |=> !roundOut[0]); // R5

endmodule

// File: rtl/cplx_bfly_datapath.sv
module cplx_bfly_datapath
  import cplx_bfly_pkg::*;
#(
  parameter int IWIDTH   = 16,
  parameter int CWIDTH   = 20,
  localparam int OWIDTH  = IWIDTH + 1,
  localparam int SHIFT   = CWIDTH - 2,
  localparam int RW      = OWIDTH + SHIFT
) (
  input  logic                clk,
  input  bflyCtrl_t           ctrl,
  input  logic [2*CWIDTH-1:0] coef,
  input  logic [2*IWIDTH-1:0] leftIn,
  input  logic [2*IWIDTH-1:0] rightIn,
  output logic [2*OWIDTH-1:0] leftOut,
  output logic [2*OWIDTH-1:0] rightOut
);

  // Unpacked operand views, {real, imag}.
  logic signed [IWIDTH-1:0] lRe, lIm, rRe, rIm;
  logic signed [CWIDTH-1:0] cRe, cIm;

  assign lRe = $signed(leftIn[2*IWIDTH-1:IWIDTH]);
  assign lIm = $signed(leftIn[IWIDTH-1:0]);
  assign rRe = $signed(rightIn[2*IWIDTH-1:IWIDTH]);
  assign rIm = $signed(rightIn[IWIDTH-1:0]);
  assign cRe = $signed(coef[2*CWIDTH-1:CWIDTH]);
  assign cIm = $signed(coef[CWIDTH-1:0]);

  // Stage 1: differences and held coefficient.
  logic signed [IWIDTH:0]   diffRe, diffIm;
  logic signed [CWIDTH-1:0] coefRe, coefIm;
  // Stage 2: four partial products, kept modulo 2^RW.
  logic signed [RW-1:0]     mulRR, mulII, mulRI, mulIR;
  // Stage 3: combined products, one per lane (0 real, 1 imag).
  logic        [RW-1:0]     combVal [2];
  // Sum path delay line, matched to the product pipeline.
  logic [2*OWIDTH-1:0]      leftPipe [BFLY_LATENCY];
  logic [OWIDTH-1:0]        laneOut  [2];

  always_ff @(posedge clk) begin
    if (ctrl.clear) begin
      diffRe <= '0;
      diffIm <= '0;
      coefRe <= '0;
      coefIm <= '0;
    end else if (ctrl.advance) begin
      diffRe <= (IWIDTH+1)'(lRe) - (IWIDTH+1)'(rRe);
      diffIm <= (IWIDTH+1)'(lIm) - (IWIDTH+1)'(rIm);
      coefRe <= cRe;
      coefIm <= cIm;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear) begin
      mulRR <= '0;
      mulII <= '0;
      mulRI <= '0;
      mulIR <= '0;
    end else if (ctrl.advance) begin
      mulRR <= RW'(coefRe) * RW'(diffRe);
      mulII <= RW'(coefIm) * RW'(diffIm);
      mulRI <= RW'(coefRe) * RW'(diffIm);
      mulIR <= RW'(coefIm) * RW'(diffRe);
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear) begin
      combVal[0] <= '0;
      combVal[1] <= '0;
    end else if (ctrl.advance) begin
      combVal[0] <= mulRR - mulII;
      combVal[1] <= mulRI + mulIR;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear) begin
      for (int i = 0; i < BFLY_LATENCY; i++) leftPipe[i] <= '0;
    end else if (ctrl.advance) begin
      leftPipe[0] <= {OWIDTH'(lRe) + OWIDTH'(rRe), OWIDTH'(lIm) + OWIDTH'(rIm)};
      for (int i = 1; i < BFLY_LATENCY; i++) leftPipe[i] <= leftPipe[i-1];
    end
  end

  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    cplx_bfly_round #(
      .OWIDTH(OWIDTH),
      .SHIFT (SHIFT)
    ) u_round (
      .clk     (clk),
      .ctrl    (ctrl),
      .prodIn  (combVal[lane]),
      .roundOut(laneOut[lane])
    );
  end

  assign leftOut  = leftPipe[BFLY_LATENCY-1];
  assign rightOut = {laneOut[0], laneOut[1]};

  AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (ctrl.clear)
    !ctrl.advance |=> $stable(leftOut)); // R8

  AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (ctrl.clear)
    !ctrl.advance |=> $stable(rightOut)); // R8

endmodule

// File: rtl/cplx_butterfly.sv
module cplx_butterfly
  import cplx_bfly_pkg::*;
#(
  parameter int IWIDTH = 16,
  parameter int CWIDTH = 20
) (
  input  logic                      i_clk,
  input  logic                      i_reset,
  input  logic                      i_ce,
  input  logic [2*CWIDTH-1:0]       i_coef,
  input  logic [2*IWIDTH-1:0]       i_left,
  input  logic [2*IWIDTH-1:0]       i_right,
  input  logic                      i_sync,
  output logic [2*(IWIDTH+1)-1:0]   o_left,
  output logic [2*(IWIDTH+1)-1:0]   o_right,
  output logic                      o_sync
);

  bflyCtrl_t stepCtrl;

  cplx_bfly_ctrl #(
    .LATENCY(BFLY_LATENCY)
  ) u_ctrl (
    .clk    (i_clk),
    .rst    (i_reset),
    .ce     (i_ce),
    .syncIn (i_sync),
    .ctrl   (stepCtrl),
    .syncOut(o_sync)
  );

  cplx_bfly_datapath #(
    .IWIDTH(IWIDTH),
    .CWIDTH(CWIDTH)
  ) u_datapath (
    .clk     (i_clk),
    .ctrl    (stepCtrl),
    .coef    (i_coef),
    .leftIn  (i_left),
    .rightIn (i_right),
    .leftOut (o_left),
    .rightOut(o_right)
  );

endmodule

// File: tb/cplx_butterfly_bench.sv
module cplx_butterfly_bench;

  localparam int CLK_PERIOD = 10;
  localparam int IW = 12;
  localparam int CW = 16;
  localparam int OW = IW + 1;
  localparam int SH = CW - 2;
  localparam int LAT = 4;

  logic              clk = 1'b0;
  logic              i_reset, i_ce, i_sync;
  logic [2*CW-1:0]   i_coef;
  logic [2*IW-1:0]   i_left, i_right;
  logic [2*OW-1:0]   o_left, o_right;
  logic              o_sync;

  int checks = 0;
  int errors = 0;

  logic [2*OW-1:0] expL [LAT];
  logic [2*OW-1:0] expR [LAT];
  logic            expS [LAT];

  always #(CLK_PERIOD/2) clk = ~clk;

  cplx_butterfly #(.IWIDTH(IW), .CWIDTH(CW)) u_cplx_butterfly (
    .i_clk(clk), .i_reset(i_reset), .i_ce(i_ce), .i_coef(i_coef),
    .i_left(i_left), .i_right(i_right), .i_sync(i_sync),
    .o_left(o_left), .o_right(o_right), .o_sync(o_sync)
  );

  function automatic logic [OW-1:0] roundEven(longint p);
    longint bias = ((p >>> SH) & 1) != 0 ? (longint'(1) <<< (SH-1))
                                          : (longint'(1) <<< (SH-1)) - 1;
    longint q = (p + bias) >>> SH;
    return OW'(q);
  endfunction

  function automatic logic [2*OW-1:0] modelLeft(logic [2*IW-1:0] l, logic [2*IW-1:0] r);
    longint sr = longint'($signed(l[2*IW-1:IW])) + longint'($signed(r[2*IW-1:IW]));
    longint si = longint'($signed(l[IW-1:0]))    + longint'($signed(r[IW-1:0]));
    return {OW'(sr), OW'(si)};
  endfunction

  function automatic logic [2*OW-1:0] modelRight(logic [2*IW-1:0] l, logic [2*IW-1:0] r,
                                                 logic [2*CW-1:0] c);
    longint dr = longint'($signed(l[2*IW-1:IW])) - longint'($signed(r[2*IW-1:IW]));
    longint di = longint'($signed(l[IW-1:0]))    - longint'($signed(r[IW-1:0]));
    longint cr = longint'($signed(c[2*CW-1:CW]));
    longint ci = longint'($signed(c[CW-1:0]));
    return {roundEven(cr*dr - ci*di), roundEven(cr*di + ci*dr)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at the falling edge, model at the rising edge,
  // compare at the next falling edge.
  task automatic runCycle(input logic rst, input logic ce, input logic sync,
                          input logic [2*IW-1:0] l, input logic [2*IW-1:0] r,
                          input logic [2*CW-1:0] c, input string tag);
    string dTag;
    string sTag;
    i_reset = rst; i_ce = ce; i_sync = sync;
    i_left = l; i_right = r; i_coef = c;
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < LAT; i++) begin expL[i] = '0; expR[i] = '0; expS[i] = 1'b0; end
    end else if (ce) begin
      for (int i = LAT-1; i > 0; i--) begin
        expL[i] = expL[i-1]; expR[i] = expR[i-1]; expS[i] = expS[i-1];
      end
      expL[0] = modelLeft(l, r);
      expR[0] = modelRight(l, r, c);
      expS[0] = sync;
    end
    @(negedge clk);
    dTag = rst ? "R9" : (ce ? tag : "R8");
    sTag = rst ? "R9" : (ce ? "R7" : "R8");
    check(o_left  == expL[LAT-1], {dTag, " left"},  64'(o_left),  64'(expL[LAT-1]));
    check(o_right == expR[LAT-1], {dTag, " right"}, 64'(o_right), 64'(expR[LAT-1]));
    check(o_sync  == expS[LAT-1], {sTag, " sync"},  64'(o_sync),  64'(expS[LAT-1]));
  endtask

  function automatic logic [2*CW-1:0] packC(int re, int im);
    return {CW'(re), CW'(im)};
  endfunction

  function automatic logic [2*IW-1:0] packS(int re, int im);
    return {IW'(re), IW'(im)};
  endfunction

  function automatic logic [IW-1:0] pickField();
    int sel = int'($urandom % 8);
    case (sel)
      0: return {1'b0, {(IW-1){1'b1}}};
      1: return {1'b1, {(IW-1){1'b0}}};
      default: return IW'($urandom);
    endcase
  endfunction

  initial begin
    int tieVals [8];
    tieVals = '{1, 3, 5, 7, -1, -3, -5, -7};
    void'($urandom(32'd4242));
    for (int i = 0; i < LAT; i++) begin expL[i] = '0; expR[i] = '0; expS[i] = 1'b0; end
    i_reset = 1'b1; i_ce = 1'b0; i_sync = 1'b0;
    i_left = '0; i_right = '0; i_coef = '0;
    @(negedge clk);
    // R9: reset state
    runCycle(1'b1, 1'b1, 1'b1, packS(3, 4), packS(5, 6), packC(1, 1), "R9");
    runCycle(1'b1, 1'b0, 1'b0, '0, '0, '0, "R9");

    // R1: packing, unit coefficient; left {5,0} right {0,2}
    runCycle(1'b0, 1'b1, 1'b1, packS(5, 0), packS(0, 2), packC(1 << SH, 0), "R1");
    for (int k = 0; k < LAT; k++)
      runCycle(1'b0, 1'b1, 1'b0, '0, '0, packC(1 << SH, 0), "R1");

    // R5: ties with coefficient 0.5 on odd differences, both signs
    for (int k = 0; k < 8; k++)
      runCycle(1'b0, 1'b1, 1'b0, packS(tieVals[k], tieVals[k]), '0,
               packC(1 << (SH-1), 0), "R5");

    // R7: single sync with stalls between enabled cycles
    runCycle(1'b0, 1'b1, 1'b1, packS(1, 1), '0, packC(1 << SH, 0), "R7");
    for (int k = 0; k < 12; k++)
      runCycle(1'b0, (k % 3) == 0, 1'b0, '0, '0, '0, "R7");

    // R6: most negative coefficient times largest difference wraps
    runCycle(1'b0, 1'b1, 1'b0, packS((1 << (IW-1)) - 1, -(1 << (IW-1))),
             packS(-(1 << (IW-1)), (1 << (IW-1)) - 1), packC(-(1 << (CW-1)), 0), "R6");
    runCycle(1'b0, 1'b1, 1'b0, packS(-(1 << (IW-1)), -(1 << (IW-1))),
             packS(-(1 << (IW-1)), (1 << (IW-1)) - 1),
             packC(-(1 << (CW-1)), -(1 << (CW-1))), "R6");

    // R2 R3 R4 R8: random operands, random enable and sync
    for (int k = 0; k < 3000; k++) begin
      logic [2*CW-1:0] c;
      c = ($urandom % 6 == 0) ? packC(-(1 << (CW-1)), (1 << (CW-1)) - 1) : 2*CW'($urandom);
      runCycle(1'b0, ($urandom % 4) != 0, ($urandom % 10) == 0,
               {pickField(), pickField()}, {pickField(), pickField()}, c, "R2 R3 R4 R6");
    end

    // R9: reset in mid-stream clears a full pipeline
    runCycle(1'b0, 1'b1, 1'b1, packS(100, -100), packS(7, 9), packC(1 << SH, 1 << SH), "R2");
    runCycle(1'b0, 1'b1, 1'b1, packS(-50, 20), packS(3, 3), packC(1 << SH, 0), "R2");
    runCycle(1'b1, 1'b1, 1'b1, packS(1, 1), packS(1, 1), packC(1, 1), "R9");
    for (int k = 0; k < LAT + 2; k++)
      runCycle(1'b0, 1'b1, 1'b0, '0, '0, '0, "R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule